// File: doc/BRIEF.md
# Burst-to-Packet Network Interface Initiator

This block sits between a processor's burst write port and the first switch of an on-chip network. Each burst the core issues becomes one packet: a header flit, then one payload flit per beat, with the last payload flit marked as tail. The header carries a hop-by-hop route. The route comes from a small table indexed by the top bits of the burst address, and the table is loaded through a configuration port. Because the route is fixed at the source, switches downstream only follow it and never compute it.

The core runs on a clock that is the network clock divided by 1, 2, 4 or 8. The whole block runs on the network clock. A counter generates a one-cycle enable (`core_ce`) that marks each core clock edge, and core-side inputs are sampled only on those cycles. Flits wait in a small buffer. A flit leaves only while the switch's stall input is low. When the buffer is full, the block stalls the core.

Top module: `bni_initiator`

## Requirements
- R1: An accepted burst of length N produces exactly N+1 flits in order: one header flit with `flit_head`=1 and `flit_tail`=0, then N payload flits carrying the beats in the order they were accepted. Only the last payload flit has `flit_tail`=1, and no flit has both marks set.
- R2: The header flit's data is {address bits [11:0] in bits 31:20, burst length in bits 19:16, route in bits 15:0}.
- R3: The route in a header is read from table entry `cmd_addr[14:12]`. A `cfg_we` write sets that entry. The write applies only to commands accepted in a later cycle, so a command accepted in the same cycle as a write to its own entry gets the old route. All entries reset to 0.
- R4: A burst of length 1 produces a header flit followed by a single payload flit that has `flit_tail`=1. Legal lengths are 1 to 15.
- R5: `core_ce` pulses once every 2^`ratio_sel` network cycles (`ratio_sel` 0..3 gives ratios 1, 2, 4, 8), so it is high every cycle at ratio 1. A command or beat is taken only in a cycle where `core_ce` is high.
- R6: `flit_valid` is never high while `sw_stall` is high. Every cycle with `flit_valid` high hands one flit to the switch. No flit is lost or repeated while the switch stalls.
- R7: `cmd_ready` is high only when no burst is in progress and the buffer is not full. A command is accepted when `core_ce`, `cmd_valid` and `cmd_ready` are all high. `cmd_ready` is low from the cycle after acceptance until the last beat is taken.
- R8: `core_stall` is high whenever the buffer holds DEPTH (4) flits. A beat offered while `core_stall` is high is not taken, and the buffer never holds more than DEPTH flits.
- R9: After reset, `flit_valid` and `core_stall` are 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Network clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ratio_sel | input | 2 | Core clock division: ratio is 2^ratio_sel |
| core_ce | output | 1 | One-cycle pulse marking each core clock edge |
| cmd_valid | input | 1 | Core offers a burst command |
| cmd_addr | input | 15 | Burst address; bits 14:12 select the route entry |
| cmd_len | input | 4 | Burst length in beats (1..15) |
| cmd_ready | output | 1 | Port free for a new command |
| beat_valid | input | 1 | Core offers a data beat |
| beat_data | input | 32 | Beat payload |
| core_stall | output | 1 | Buffer full; beats are not taken |
| cfg_we | input | 1 | Route table write strobe |
| cfg_idx | input | 3 | Route table entry to write |
| cfg_path | input | 16 | Route value to write |
| sw_stall | input | 1 | Stall flag from the attached switch |
| flit_valid | output | 1 | A flit is sent this cycle |
| flit_head | output | 1 | Sent flit is a header |
| flit_tail | output | 1 | Sent flit ends the packet |
| flit_data | output | 32 | Flit payload |

## Verification
Two pairs of events can land in the same cycle. In the first pair, a route table write and a header lookup for the same entry coincide. The bench raises `cfg_we` on the entry at the exact edge where its command is accepted, and expects the old route in that header and the new one in the next. In the second pair, a push from the core and a pop to the switch coincide while the buffer is at its limit. Random switch stalls against fixed and divided core ratios provoke this, and a scoreboard that tracks every flit in order judges the result. A forced long stall then confirms that `core_stall` holds and that no beat is dropped or repeated.

// File: rtl/bni_pkg.sv
package bni_pkg;

  typedef enum logic {
    PK_IDLE = 1'b0,
    PK_DATA = 1'b1
  } pk_state_t;

  // Number of network cycles per core cycle for a division select.
  function automatic int unsigned ratio_period(input int unsigned sel);
    return 32'd1 << sel;
  endfunction

endpackage

// File: rtl/bni_phase_gen.sv
module bni_phase_gen #(
  parameter int RSW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RSW-1:0] ratio_sel,
  output logic           core_ce
);
  import bni_pkg::*;

  localparam int CNTW = (1 << RSW) - 1;

  logic [CNTW-1:0] cnt;
  logic [CNTW-1:0] mask;

  assign mask    = CNTW'(ratio_period(32'(ratio_sel)) - 1);
  assign core_ce = ((cnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/bni_path_table.sv
module bni_path_table #(
  parameter int IW = 3,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [PW-1:0] wr_path,
  input  logic [IW-1:0] rd_idx,
  output logic [PW-1:0] rd_path
);
  localparam int NT = 1 << IW;

  logic [PW-1:0] tbl [NT];

  genvar g;
  generate
    for (g = 0; g < NT; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                tbl[g] <= '0;
        else if (wr_en && (wr_idx == IW'(g)))      tbl[g] <= wr_path;
      end
    end
  endgenerate

  assign rd_path = tbl[rd_idx];

endmodule

// File: rtl/bni_flit_fifo.sv
module bni_flit_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] fill
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [W-1:0]    mem [DEPTH];
  logic [PTRW-1:0] wptr, rptr;

  assign empty    = (fill == '0);
  assign full     = (fill == CW'(DEPTH));
  assign pop_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

endmodule

// File: rtl/bni_packetizer.sv
module bni_packetizer #(
  parameter int AW = 15,
  parameter int DW = 32,
  parameter int LW = 4,
  parameter int PW = 16,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_len,
  input  logic          beat_valid,
  input  logic [DW-1:0] beat_data,
  input  logic [PW-1:0] route_path,
  input  logic          buf_full,
  output logic [IW-1:0] route_idx,
  output logic          cmd_ready,
  output logic          cmd_fire,
  output logic          beat_fire,
  output logic          push,
  output logic [DW+1:0] push_flit
);
  import bni_pkg::*;

  localparam int HAW = DW - PW - LW;

  // Header: address low bits, then length, then route in the low bits.
  function automatic logic [DW-1:0] make_header(input logic [HAW-1:0] a,
                                                input logic [LW-1:0]  n,
                                                input logic [PW-1:0]  p);
    return {a, n, p};
  endfunction

  pk_state_t     state;
  logic [LW-1:0] left;
  logic          last_beat;

  assign route_idx = cmd_addr[AW-1 -: IW];
  assign cmd_ready = (state == PK_IDLE) && !buf_full;
  assign cmd_fire  = ce && cmd_valid && cmd_ready;
  assign beat_fire = ce && beat_valid && (state == PK_DATA) && !buf_full;
  assign last_beat = (left == LW'(1));
  assign push      = cmd_fire || beat_fire;

  always_comb begin
    if (cmd_fire)
      push_flit = {1'b1, 1'b0, make_header(cmd_addr[HAW-1:0], cmd_len, route_path)};
    else
      push_flit = {1'b0, last_beat, beat_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PK_IDLE;
      left  <= '0;
    end else if (cmd_fire) begin
      state <= PK_DATA;
      left  <= cmd_len;
    end else if (beat_fire) begin
      left <= left - 1'b1;
      if (last_beat) state <= PK_IDLE;
    end
  end

endmodule

// File: rtl/bni_initiator.sv
module bni_initiator #(
  parameter int AW    = 15,
  parameter int DW    = 32,
  parameter int LW    = 4,
  parameter int PW    = 16,
  parameter int IW    = 3,
  parameter int RSW   = 2,
  parameter int DEPTH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RSW-1:0] ratio_sel,
  output logic           core_ce,
  input  logic           cmd_valid,
  input  logic [AW-1:0]  cmd_addr,
  input  logic [LW-1:0]  cmd_len,
  output logic           cmd_ready,
  input  logic           beat_valid,
  input  logic [DW-1:0]  beat_data,
  output logic           core_stall,
  input  logic           cfg_we,
  input  logic [IW-1:0]  cfg_idx,
  input  logic [PW-1:0]  cfg_path,
  input  logic           sw_stall,
  output logic           flit_valid,
  output logic           flit_head,
  output logic           flit_tail,
  output logic [DW-1:0]  flit_data
);
  localparam int FW = DW + 2;
  localparam int CW = $clog2(DEPTH + 1);

  // Named internal events, also observed by the checker.
  logic          push_w;
  logic          pop_w;
  logic          cmd_fire_w;
  logic          beat_fire_w;
  logic          buf_full_w;
  logic          buf_empty_w;
  logic [CW-1:0] buf_fill_w;
  logic [FW-1:0] push_flit_w;
  logic [FW-1:0] pop_flit_w;
  logic [IW-1:0] route_idx_w;
  logic [PW-1:0] route_path_w;

  bni_phase_gen #(.RSW(RSW)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_sel (ratio_sel),
    .core_ce   (core_ce)
  );

  bni_path_table #(.IW(IW), .PW(PW)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_path (cfg_path),
    .rd_idx  (route_idx_w),
    .rd_path (route_path_w)
  );

  bni_packetizer #(.AW(AW), .DW(DW), .LW(LW), .PW(PW), .IW(IW)) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce         (core_ce),
    .cmd_valid  (cmd_valid),
    .cmd_addr   (cmd_addr),
    .cmd_len    (cmd_len),
    .beat_valid (beat_valid),
    .beat_data  (beat_data),
    .route_path (route_path_w),
    .buf_full   (buf_full_w),
    .route_idx  (route_idx_w),
    .cmd_ready  (cmd_ready),
    .cmd_fire   (cmd_fire_w),
    .beat_fire  (beat_fire_w),
    .push       (push_w),
    .push_flit  (push_flit_w)
  );

  bni_flit_fifo #(.W(FW), .DEPTH(DEPTH), .CW(CW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_w),
    .push_data (push_flit_w),
    .pop       (pop_w),
    .pop_data  (pop_flit_w),
    .empty     (buf_empty_w),
    .full      (buf_full_w),
    .fill      (buf_fill_w)
  );

  assign pop_w      = !buf_empty_w && !sw_stall;
  assign flit_valid = pop_w;
  assign flit_head  = pop_flit_w[FW-1];
  assign flit_tail  = pop_flit_w[FW-2];
  assign flit_data  = pop_flit_w[DW-1:0];
  assign core_stall = buf_full_w;

endmodule

// File: rtl/bni_initiator_chk.sv
module bni_initiator_chk #(
  parameter int RSW   = 2,
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [RSW-1:0] ratio_sel,
  input logic           core_ce,
  input logic           push,
  input logic           cmd_fire,
  input logic           cmd_ready,
  input logic           core_stall,
  input logic           sw_stall,
  input logic           flit_valid,
  input logic           flit_head,
  input logic           flit_tail,
  input logic [CW-1:0]  fill
);

  a_r5_full_rate_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_sel == '0) |-> core_ce);

  a_r5_push_on_ce: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> core_ce);

  a_r6_no_flit_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid |-> !sw_stall);

  a_r1_head_not_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid && flit_head) |-> !flit_tail);

  a_r7_busy_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> !cmd_ready);

  a_r8_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  a_r8_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == CW'(DEPTH)) |-> (core_stall && !cmd_ready));

endmodule

bind bni_initiator bni_initiator_chk #(.RSW(RSW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ratio_sel  (ratio_sel),
  .core_ce    (core_ce),
  .push       (push_w),
  .cmd_fire   (cmd_fire_w),
  .cmd_ready  (cmd_ready),
  .core_stall (core_stall),
  .sw_stall   (sw_stall),
  .flit_valid (flit_valid),
  .flit_head  (flit_head),
  .flit_tail  (flit_tail),
  .fill       (buf_fill_w)
);

// File: tb/tb_bni_initiator.sv
module tb_bni_initiator;
  localparam int AW = 15;
  localparam int DW = 32;
  localparam int LW = 4;
  localparam int PW = 16;
  localparam int IW = 3;

  typedef struct packed {
    logic          head;
    logic          tail;
    logic [DW-1:0] data;
  } flit_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    ratio_sel;
  logic          core_ce;
  logic          cmd_valid;
  logic [AW-1:0] cmd_addr;
  logic [LW-1:0] cmd_len;
  logic          cmd_ready;
  logic          beat_valid;
  logic [DW-1:0] beat_data;
  logic          core_stall;
  logic          cfg_we;
  logic [IW-1:0] cfg_idx;
  logic [PW-1:0] cfg_path;
  logic          sw_stall;
  logic          flit_valid;
  logic          flit_head;
  logic          flit_tail;
  logic [DW-1:0] flit_data;

  always #2 clk = ~clk;

  bni_initiator dut (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .core_ce(core_ce),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_ready(cmd_ready),
    .beat_valid(beat_valid), .beat_data(beat_data), .core_stall(core_stall),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_path(cfg_path), .sw_stall(sw_stall),
    .flit_valid(flit_valid), .flit_head(flit_head), .flit_tail(flit_tail), .flit_data(flit_data)
  );

  int    checks = 0;
  int    fails  = 0;
  int    flits_seen = 0;
  int    flits_expected = 0;
  int    stall_viol = 0;
  bit    stall_rand = 0;
  bit    stall_force = 0;
  logic [15:0]   lfsr = 16'hACE1;
  logic [PW-1:0] model [8];
  flit_t exp_q [$];
  string tag_q [$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Switch stall generator: forced or pseudo-random.
  initial begin
    sw_stall = 1'b0;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sw_stall = stall_force | (stall_rand & lfsr[0]);
    end
  end

  // Monitor: compares each sent flit with the scoreboard head.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && flit_valid) begin
        flit_t got;
        got = '{flit_head, flit_tail, flit_data};
        flits_seen++;
        if (sw_stall) stall_viol++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected flit", 64'(got), 64'h0);
        end else begin
          flit_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(got == e, t, 64'(got), 64'(e));
        end
      end
    end
  end

  task automatic expect_flit(input flit_t f, input string tag);
    exp_q.push_back(f);
    tag_q.push_back(tag);
    flits_expected++;
  endtask

  task automatic cfg_write(input int idx, input logic [PW-1:0] p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_path = p;
    model[idx] = p;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Driver: issues one burst, predicts its flits (R1, R2, R3, R4).
  task automatic send_burst(input logic [AW-1:0] addr, input int len,
                            input logic [DW-1:0] base, input bit clash);
    int idx;
    logic [DW-1:0] hdr;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = addr; cmd_len = LW'(len);
    while (!(core_ce && cmd_ready)) @(negedge clk);
    idx = int'(addr[14:12]);
    hdr = {addr[11:0], 4'(len), model[idx]};
    expect_flit('{1'b1, 1'b0, hdr}, clash ? "R3 same-cycle write keeps old route" : "R2 header layout");
    if (clash) begin
      cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_path = ~model[idx];
      model[idx] = ~model[idx];
    end
    @(negedge clk);
    cfg_we = 1'b0;
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R7 busy during burst", 64'(cmd_ready), 64'h0);
    for (int i = 0; i < len; i++) begin
      beat_valid = 1'b1;
      beat_data  = base + DW'(i);
      while (!(core_ce && !core_stall)) @(negedge clk);
      expect_flit('{1'b0, (i == len - 1), base + DW'(i)},
                  (len == 1) ? "R4 single beat tail" : "R1 payload order");
      @(negedge clk);
    end
    beat_valid = 1'b0;
  endtask

  task automatic measure_ratio(input int sel);
    int gap;
    @(negedge clk);
    ratio_sel = 2'(sel);
    repeat (20) @(negedge clk);
    while (!core_ce) @(negedge clk);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!core_ce);
    check(gap == (1 << sel), "R5 enable period", 64'(gap), 64'(1 << sel));
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; ratio_sel = 2'd0; cmd_valid = 1'b0; cmd_addr = '0; cmd_len = '0;
    beat_valid = 1'b0; beat_data = '0; cfg_we = 1'b0; cfg_idx = '0; cfg_path = '0;
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R9 reset state
    check(flit_valid == 1'b0, "R9 flit_valid after reset", 64'(flit_valid), 64'h0);
    check(core_stall == 1'b0, "R9 core_stall after reset", 64'(core_stall), 64'h0);
    check(cmd_ready == 1'b1, "R9 cmd_ready after reset", 64'(cmd_ready), 64'h1);

    for (int s = 0; s < 4; s++) measure_ratio(s);

    ratio_sel = 2'd0;
    // Reset route is zero for entry 5 (R3)
    send_burst({3'd5, 12'h0AB}, 2, 32'h0000_0100, 1'b0);
    for (int i = 0; i < 8; i++) cfg_write(i, 16'h0F00 ^ PW'(i * 16'h1357));

    // Ratio 1, no stall: R4 length 1, mid and maximum lengths
    send_burst({3'd1, 12'h123}, 1, 32'h1000_0000, 1'b0);
    send_burst({3'd2, 12'h456}, 3, 32'h2000_0000, 1'b0);
    send_burst({3'd7, 12'hFFF}, 15, 32'h3000_0000, 1'b0);
    drain();

    // Random switch stalls at ratio 1, 4 and 8
    stall_rand = 1'b1;
    send_burst({3'd3, 12'h010}, 5, 32'h4000_0000, 1'b0);
    send_burst({3'd0, 12'h020}, 1, 32'h4100_0000, 1'b0);
    ratio_sel = 2'd2;
    send_burst({3'd4, 12'h030}, 6, 32'h5000_0000, 1'b0);
    send_burst({3'd6, 12'h040}, 1, 32'h5100_0000, 1'b0);
    ratio_sel = 2'd3;
    send_burst({3'd5, 12'h050}, 4, 32'h6000_0000, 1'b0);
    ratio_sel = 2'd1;
    send_burst({3'd2, 12'h060}, 7, 32'h6100_0000, 1'b0);
    drain();

    // R3: write to the same entry in the acceptance cycle
    stall_rand = 1'b0;
    ratio_sel = 2'd0;
    send_burst({3'd3, 12'h777}, 2, 32'h7000_0000, 1'b1);
    send_burst({3'd3, 12'h778}, 1, 32'h7100_0000, 1'b0);
    drain();

    // R8: forced stall fills the buffer and stalls the core
    stall_force = 1'b1;
    repeat (2) @(negedge clk);
    begin
      int seen_before;
      seen_before = flits_seen;
      fork
        send_burst({3'd6, 12'h888}, 8, 32'h8000_0000, 1'b0);
      join_none
      repeat (20) @(negedge clk);
      check(core_stall == 1'b1, "R8 full buffer stalls core", 64'(core_stall), 64'h1);
      check(cmd_ready == 1'b0, "R8 no command when full", 64'(cmd_ready), 64'h0);
      check(flits_seen == seen_before, "R6 nothing sent under stall",
            64'(flits_seen), 64'(seen_before));
      stall_force = 1'b0;
      wait fork;
    end
    drain();

    check(stall_viol == 0, "R6 flit during switch stall", 64'(stall_viol), 64'h0);
    check(exp_q.size() == 0, "R1 all flits delivered", 64'(exp_q.size()), 64'h0);
    check(flits_seen == flits_expected, "R1 flit count", 64'(flits_seen), 64'(flits_expected));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule